// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the serial register-access front end of a sampling converter. A host opens a frame by pulling the active-low frame strobe low. It then clocks an 8-bit command and one data byte through a four-wire serial link. The block holds one 8-bit configuration byte. That byte carries four mode enables, three reserved bits that always read 1, and a sticky active-low overvoltage flag. The flag is set from a status input. The four mode enables drive parallel outputs for the rest of the converter.

All serial pins are sampled by the block's own system clock through a synchronizer. The serial clock must therefore run well below the system clock: each serial clock phase must last at least four system clock cycles. Data is taken on rising serial clock edges and presented on falling ones. The serial output is returned as a data bit plus an output enable, so the pad can be tri-stated at the chip level. A daisy-chain mode input changes how the output is released after a frame and disables register reads.

Top module: `cfg_spi_port`

## Requirements
- R1: After reset, all four mode outputs are 0 and the configuration byte reads back as 0xE1. Bits 7..5 read 1, bits 4..1 read 0, and bit 0 (the flag) reads 1.
- R2: Within a frame, every SDI bit of value 1 taken before the first 0 is skipped. That first 0 becomes command bit 7 (the active-low write enable), and the next seven rising SCK edges fill command bits 6..0.
- R3: Command bits 5..0 must equal 010100. Bit 6 = 1 requests a read and bit 6 = 0 requests a write. Any other pattern in bits 5..0 is ignored for the rest of the frame: no register change occurs and SDO stays 0.
- R4: After a valid write command, the next eight SDI bits, MSB first, form a data byte. Its bits 4..1 update the enables: bit 4 drives `six_status_o`, bit 3 drives `span_comp_o`, bit 2 drives `hiz_o` and bit 1 drives `turbo_o`. Data bits 7..5 and 0 are discarded, so reserved bits still read 1 and the flag is unchanged.
- R5: If the strobe rises before all eight write data bits have arrived, the write is abandoned and the register is unchanged.
- R6: After a valid read command, the configuration byte is shifted out MSB first on SDO. Each bit changes on a falling SCK edge, starting with the fall that follows the 8th command bit, so the host captures it on rising edges 9 to 16.
- R7: While `ovr_i` is high, the flag bit reads 0. Once it is 0, it stays 0 until it is cleared as R8 describes.
- R8: The flag returns to 1 only when the strobe rises at the end of a frame in which all eight read bits were shifted out, and only if `ovr_i` is low at that moment. The byte shifted out is a snapshot taken at the command, and it never changes during the read.
- R9: While a frame is open, `sdo_oe_o` is 1. Outside a frame, with `chain_i` low, `sdo_oe_o` is 0. With `chain_i` high, `sdo_oe_o` is 1 and `sdo_o` is 0.
- R10: While `chain_i` is high, read commands are ignored: SDO stays 0 and the flag is not cleared. Write commands still update the register.
- R11: A rising strobe ends the frame at any point. The next frame starts again by skipping leading 1s, whatever partial command came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnv_n_i | input | 1 | Frame strobe; register access while low |
| sck_i | input | 1 | Serial clock from host, idles low |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| ovr_i | input | 1 | Overvoltage condition, active high, synchronous to clk |
| chain_i | input | 1 | Daisy-chain mode select |
| six_status_o | output | 1 | Six-status-bit enable |
| span_comp_o | output | 1 | Span compression enable |
| hiz_o | output | 1 | High-impedance mode enable |
| turbo_o | output | 1 | Turbo mode enable |

## Verification
Each pin edge passes through two synchronizer flops and one edge-detect flop. The register then needs one more cycle. So the mode outputs settle four clock cycles after the 16th rising SCK edge, SDO settles three cycles after each falling edge, and the flag settles three cycles after the strobe rises. The bench holds each SCK phase for eight clock cycles. It captures SDO just before each rising edge, as a host would. It checks the mode outputs, output enable and flag only after the strobe has been high for twelve cycles, so every result is sampled after it is due.

// File: rtl/cfg_spi_pkg.sv
// Package: shared widths, constants and the frame decoder state type.
// Assumes: one 8-bit configuration byte; the command tag is fixed by the protocol.
package cfg_spi_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam int MODE_W   = 4;
    localparam int RSV_W    = BYTE_W - MODE_W - 1;
    localparam logic [5:0]  CMD_TAG   = 6'b010100;
    localparam int          CMD_RD_BIT = 6;
    localparam logic [BYTE_W-1:0] CFG_RESET = 8'hE1;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HUNT  = 3'd1,
        ST_CMD   = 3'd2,
        ST_WDATA = 3'd3,
        ST_RDATA = 3'd4,
        ST_DONE  = 3'd5
    } frame_st_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings the strobe, serial clock and serial data into the clk domain
// through a STAGES-deep flop chain, and reports serial clock edges and a rising
// strobe as single-cycle pulses.
// Assumes: each SCK phase lasts at least STAGES+2 clk cycles, and SDI is stable
// around the rising SCK edge, so SDI sampled alongside the SCK edge is valid.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnv_n_i,
    input  logic sck_i,
    input  logic sdi_i,
    output logic cnv_hi,
    output logic cnv_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_bit
);
    // bit 2 = strobe, bit 1 = data, bit 0 = clock
    localparam logic [2:0] PIN_RST = 3'b110;

    logic [2:0] pipe_q [0:STAGES];

    // first stage captures the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q[0] <= PIN_RST;
        else        pipe_q[0] <= {cnv_n_i, sdi_i, sck_i};
    end

    // remaining stages: synchronizer tail plus one edge-detect stage
    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q[g] <= PIN_RST;
            else        pipe_q[g] <= pipe_q[g-1];
        end
    end

    // edge and level decode on the settled stages
    always_comb begin
        cnv_hi   = pipe_q[STAGES-1][2];
        cnv_rise = pipe_q[STAGES-1][2] & ~pipe_q[STAGES][2];
        sdi_bit  = pipe_q[STAGES-1][1];
        sck_rise = pipe_q[STAGES-1][0] & ~pipe_q[STAGES][0];
        sck_fall = ~pipe_q[STAGES-1][0] & pipe_q[STAGES][0];
    end
endmodule

// File: rtl/cfg_frame_fsm.sv
// Module: cfg_frame_fsm
// Runs one frame: skips leading ones, collects the 8-bit command, checks
// its tag, then takes a write byte or shifts out the register snapshot.
// Raises a clear request when the strobe closes a frame whose read completed.
// Assumes: edge pulses come from spi_pin_sync; rise and fall never coincide.
module cfg_frame_fsm
    import cfg_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_hi,
    input  logic              cnv_rise,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi_bit,
    input  logic              chain_i,
    input  logic [BYTE_W-1:0] reg_val,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_clr,
    output logic              frame_open,
    output logic              sdo_bit
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    frame_st_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] in_sr_q;
    logic [BYTE_W-1:0] out_sr_q;
    logic              sdo_q;
    logic              read_ok_q;
    logic              wr_stb_q;
    logic [BYTE_W-1:0] in_next;

    // next input shift value, MSB first
    always_comb in_next = {in_sr_q[BYTE_W-2:0], sdi_bit};

    // frame sequencing, bit counting and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            in_sr_q   <= '0;
            out_sr_q  <= '0;
            sdo_q     <= 1'b0;
            read_ok_q <= 1'b0;
            wr_stb_q  <= 1'b0;
        end else begin
            wr_stb_q <= 1'b0;
            if (cnv_hi) begin
                state_q   <= ST_IDLE;
                cnt_q     <= '0;
                sdo_q     <= 1'b0;
                read_ok_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        state_q <= ST_HUNT;
                        sdo_q   <= 1'b0;
                    end
                    ST_HUNT: begin
                        if (sck_rise && !sdi_bit) begin
                            in_sr_q <= in_next;
                            cnt_q   <= CNT_W'(1);
                            state_q <= ST_CMD;
                        end
                    end
                    ST_CMD: begin
                        if (sck_rise) begin
                            in_sr_q <= in_next;
                            if (cnt_q == LAST) begin
                                cnt_q <= '0;
                                if (in_next[5:0] != CMD_TAG) begin
                                    state_q <= ST_DONE;
                                end else if (in_next[CMD_RD_BIT]) begin
                                    if (chain_i) begin
                                        state_q <= ST_DONE;
                                    end else begin
                                        out_sr_q <= reg_val;
                                        state_q  <= ST_RDATA;
                                    end
                                end else begin
                                    state_q <= ST_WDATA;
                                end
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (sck_rise) begin
                            in_sr_q <= in_next;
                            if (cnt_q == LAST) begin
                                wr_stb_q <= 1'b1;
                                state_q  <= ST_DONE;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (sck_fall) begin
                            sdo_q    <= out_sr_q[BYTE_W-1];
                            out_sr_q <= {out_sr_q[BYTE_W-2:0], 1'b0};
                        end
                        if (sck_rise) begin
                            if (cnt_q == LAST) begin
                                read_ok_q <= 1'b1;
                                state_q   <= ST_DONE;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_DONE: begin
                        if (sck_fall) sdo_q <= 1'b0;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // outputs toward the register and the pad
    always_comb begin
        wr_stb     = wr_stb_q;
        wr_data    = in_sr_q;
        rd_clr     = cnv_rise & read_ok_q;
        frame_open = (state_q != ST_IDLE);
        sdo_bit    = sdo_q;
    end

    // a high strobe always returns the decoder to idle
    p_frame_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_hi |=> (state_q == ST_IDLE));

    // a read command decoded in chain mode never starts a read
    p_chain_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD && sck_rise && !cnv_hi && cnt_q == LAST && chain_i)
        |=> (state_q != ST_RDATA));

    // a write strobe only follows a full data byte in the write state
    p_write_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_q |-> ($past(state_q) == ST_WDATA && $past(cnt_q) == LAST));
endmodule

// File: rtl/cfg_reg_bank.sv
// Module: cfg_reg_bank
// Holds the four mode enables and the sticky active-low overvoltage flag,
// and composes the readback byte with the reserved bits set.
// Assumes: ovr_i is synchronous to clk; wr_stb and rd_clr are one-cycle pulses.
module cfg_reg_bank
    import cfg_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_clr,
    input  logic              ovr_i,
    output logic [BYTE_W-1:0] reg_val,
    output logic [MODE_W-1:0] mode
);
    logic [MODE_W-1:0] mode_q;
    logic              flag_n_q;

    // mode enables: only bits 4..1 of a write land
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= CFG_RESET[MODE_W:1];
        else if (wr_stb) mode_q <= wr_data[MODE_W:1];
    end

    // sticky flag: set dominates, clear only when the condition is gone
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_n_q <= CFG_RESET[0];
        else if (ovr_i)            flag_n_q <= 1'b0;
        else if (rd_clr)           flag_n_q <= 1'b1;
    end

    // readback byte and parallel enables
    always_comb begin
        reg_val = {{RSV_W{1'b1}}, mode_q, flag_n_q};
        mode    = mode_q;
    end

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_i |=> !flag_n_q);

    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_n_q && !rd_clr) |=> !flag_n_q);

    p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(mode_q));
endmodule

// File: rtl/cfg_spi_port.sv
// Module: cfg_spi_port (top)
// Serial access port for one configuration byte: synchronizer, frame
// decoder and register bank, plus the serial output release rule.
// Assumes: SCK phases are at least four clk cycles long; pad tri-state is
// built outside from sdo_o and sdo_oe_o.
module cfg_spi_port
    import cfg_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnv_n_i,
    input  logic sck_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o,
    input  logic ovr_i,
    input  logic chain_i,
    output logic six_status_o,
    output logic span_comp_o,
    output logic hiz_o,
    output logic turbo_o
);
    logic              cnv_hi, cnv_rise, sck_rise, sck_fall, sdi_bit;
    logic              wr_stb, rd_clr, frame_open, sdo_bit;
    logic [BYTE_W-1:0] wr_data, reg_val;
    logic [MODE_W-1:0] mode;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .cnv_n_i(cnv_n_i), .sck_i(sck_i),
        .sdi_i(sdi_i), .cnv_hi(cnv_hi), .cnv_rise(cnv_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_bit(sdi_bit)
    );

    cfg_frame_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .cnv_hi(cnv_hi), .cnv_rise(cnv_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_bit(sdi_bit),
        .chain_i(chain_i), .reg_val(reg_val), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_clr(rd_clr), .frame_open(frame_open),
        .sdo_bit(sdo_bit)
    );

    cfg_reg_bank bank_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_clr(rd_clr), .ovr_i(ovr_i), .reg_val(reg_val), .mode(mode)
    );

    // pad release and mode fan-out
    always_comb begin
        sdo_oe_o     = frame_open | chain_i;
        sdo_o        = frame_open & sdo_bit;
        six_status_o = mode[3];
        span_comp_o  = mode[2];
        hiz_o        = mode[1];
        turbo_o      = mode[0];
    end

    // with the pad disabled, the data line never carries a 1
    p_quiet_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe_o |-> !sdo_o);
endmodule

// File: tb/cfg_spi_port_tb_top.sv
module cfg_spi_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnv_n = 1'b1, sck = 1'b0, sdi = 1'b1, ovr = 1'b0, chain = 1'b0;
    logic sdo, sdo_oe, six_st, span, hiz, turbo;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [63:0] rx;
    logic oe_all;
    logic [3:0] exp_mode = 4'h0;
    logic exp_flag = 1'b1;
    logic [7:0] v;

    always #10 clk = ~clk;

    cfg_spi_port dut_i (
        .clk(clk), .rst_n(rst_n), .cnv_n_i(cnv_n), .sck_i(sck), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .ovr_i(ovr), .chain_i(chain),
        .six_status_o(six_st), .span_comp_o(span), .hiz_o(hiz), .turbo_o(turbo)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one frame: n bits MSB first; SDO captured just before each rising edge
    task automatic frame(input logic [63:0] bits, input int n);
        oe_all = 1'b1;
        rx = '0;
        cnv_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            repeat (8) @(negedge clk);
            rx = {rx[62:0], sdo};
            oe_all = oe_all & sdo_oe;
            sck = 1'b1;
            repeat (8) @(negedge clk);
            sck = 1'b0;
        end
        repeat (8) @(negedge clk);
        cnv_n = 1'b1;
        sdi = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        frame({48'h0, 8'h14, d}, 16);
    endtask

    task automatic do_read(output logic [7:0] d);
        frame({48'h0, 8'h54, 8'h00}, 16);
        d = rx[7:0];
    endtask

    function automatic logic [7:0] exp_reg();
        return {3'b111, exp_mode, exp_flag};
    endfunction

    task automatic check_modes(input string req);
        check(req, {28'h0, six_st, span, hiz, turbo}, {28'h0, exp_mode});
    endtask

    task automatic t_reset();
        check("R1 modes", {28'h0, six_st, span, hiz, turbo}, 32'h0);
        check("R9 oe idle", {31'h0, sdo_oe}, 32'h0);
        do_read(v);
        check("R1 readback", {24'h0, v}, 32'hE1);
        check("R9 oe in frame", {31'h0, oe_all}, 32'h1);
    endtask

    task automatic t_write();
        do_write(8'h1E); exp_mode = 4'hF;
        check_modes("R4 all on");
        do_read(v);
        check("R6 read FF", {24'h0, v}, {24'h0, exp_reg()});
        do_write(8'hAA); exp_mode = 4'h5;
        check_modes("R4 AA");
        do_read(v);
        check("R4 reserved/flag kept", {24'h0, v}, 32'hEB);
    endtask

    task automatic t_lead_ones();
        frame({45'h0, 3'b111, 8'h14, 8'h04}, 19); exp_mode = 4'h2;
        check_modes("R2 leading ones");
        frame({59'h0, 5'b11111}, 5);
        frame({56'h0, 8'h54}, 8);
        frame({40'h0, 8'hFF, 8'h54, 8'h00}, 24);
        check("R2 read after ones", {24'h0, rx[7:0]}, {24'h0, exp_reg()});
    endtask

    task automatic t_bad_cmd();
        frame({48'h0, 8'h15, 8'h1E}, 16);
        check_modes("R3 bad write tag");
        frame({48'h0, 8'h50, 8'h00}, 16);
        check("R3 bad read tag sdo", {24'h0, rx[7:0]}, 32'h0);
        frame({48'h0, 8'h16, 8'h1E}, 16);
        check_modes("R3 bad write tag 2");
    endtask

    task automatic t_abandon();
        frame({51'h0, 8'h14, 5'b11111}, 13);
        check_modes("R5 abandoned write");
        do_read(v);
        check("R5 readback", {24'h0, v}, {24'h0, exp_reg()});
    endtask

    task automatic t_partial();
        frame({60'h0, 4'b0101}, 4);
        do_read(v);
        check("R11 read after partial", {24'h0, v}, {24'h0, exp_reg()});
        frame({58'h0, 6'b000101}, 6);
        do_write(8'h08); exp_mode = 4'h4;
        check_modes("R11 write after partial");
    endtask

    task automatic t_flag();
        ovr = 1'b1; repeat (4) @(negedge clk);
        exp_flag = 1'b0;
        do_read(v);
        check("R7 flag while ovr", {24'h0, v}, {24'h0, exp_reg()});
        ovr = 1'b0; repeat (4) @(negedge clk);
        do_write(8'h02); exp_mode = 4'h1;
        do_read(v);
        check("R8 still low, write no clear", {24'h0, v}, {24'h0, exp_reg()});
        exp_flag = 1'b1;
        do_read(v);
        check("R8 cleared by read", {24'h0, v}, {24'h0, exp_reg()});
        ovr = 1'b1; @(negedge clk); ovr = 1'b0;
        frame({52'h0, 8'h54, 4'h0}, 12);
        frame({48'h0, 8'h54, 8'h00}, 16);
        check("R8 partial read no clear", {31'h0, rx[0]}, 32'h0);
        do_read(v);
        check("R8 full read clears", {31'h0, v[0]}, 32'h1);
    endtask

    task automatic t_chain();
        chain = 1'b1; repeat (4) @(negedge clk);
        check("R9 chain oe", {31'h0, sdo_oe}, 32'h1);
        check("R9 chain sdo low", {31'h0, sdo}, 32'h0);
        ovr = 1'b1; @(negedge clk); ovr = 1'b0; exp_flag = 1'b0;
        do_read(v);
        check("R10 read blocked", {24'h0, v}, 32'h0);
        do_write(8'h10); exp_mode = 4'h8;
        check_modes("R10 write in chain");
        chain = 1'b0; repeat (4) @(negedge clk);
        check("R9 release", {31'h0, sdo_oe}, 32'h0);
        do_read(v);
        check("R10 flag kept", {24'h0, v}, {24'h0, exp_reg()});
        exp_flag = 1'b1;
        do_read(v);
        check("R8 clear after chain", {24'h0, v}, {24'h0, exp_reg()});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_lead_ones();
        t_bad_cmd();
        t_abandon();
        t_partial();
        t_flag();
        t_chain();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule